// File: doc/BRIEF.md
# Data Memory Access Router

This block sits between a small 8-bit microcontroller core and its data stores and decides, for every data access, which store serves it. The core presents an access kind, read and write strobes, an address and write data. The block drives exactly one of five select lines: lower internal RAM, upper internal RAM, the special-function-register space, the on-chip expanded RAM, or an off-chip request port. Read data comes back one clock later from whichever store answered.

Both the SFR space and the upper RAM use internal addresses 80H to FFH. They hold separate storage. For those addresses the addressing mode of the access, not the address, picks the store. For external-data moves, a two-bit auxiliary control register decides where the boundary between on-chip and off-chip storage lies. The same register also decides whether the address latch enable output runs at a constant rate or only fires for bus-type transfers. The SFR contents here are a stub store, and the off-chip port exposes only request, address, data and write-enable.

Top module: `dmem_router`

## Requirements
- R1: An access of kind direct (code 0) or indirect (code 1) to internal address 00H..7FH selects the lower RAM. Data written in either mode reads back in the other mode.
- R2: For internal addresses 80H..FFH, a direct access selects the SFR space and an indirect access selects the upper RAM. The two hold independent bytes at the same address.
- R3: The auxiliary register is reached by a direct access at 8EH and is 00H after reset. Bit 1 is the on-chip-bypass control and bit 0 is the ALE-gating control. Only those two bits are written, and bits 7..2 always read 0.
- R4: With bypass 0, an external move (code 2, 16-bit address) to 0000H..02FFH selects the 768-byte on-chip expanded RAM.
- R5: With bypass 0, an external move above 02FFH selects the off-chip port. The port presents the address, write enable and write data, and a read returns the port's input data.
- R6: With bypass 1, every external move selects the off-chip port whatever its address, and on-chip expanded RAM contents are left untouched.
- R7: An 8-bit external move (code 3) uses only address bits 7..0, zero-extended to 16 bits.
- R8: Read data and a valid flag appear in the clock cycle after the read strobe. The valid flag is low after any cycle without a read.
- R9: While a strobe is active exactly one select line is high. With no strobe, none is high.
- R10: With ALE gating 0, the ALE output is high for one clock once every 6 clocks.
- R11: With ALE gating 1, ALE is high only in the cycle after an external move or a code-read indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_kind | input | 2 | 0 direct, 1 indirect, 2 external 16-bit, 3 external 8-bit |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 16 | Access address (bits 7..0 for internal kinds) |
| wdata | input | 8 | Write data |
| code_rd | input | 1 | Code-memory read in progress (ALE gating) |
| rdata | output | 8 | Read data, one clock after the read |
| rvalid | output | 1 | Read data valid |
| sel_lo | output | 1 | Lower RAM selected |
| sel_hi | output | 1 | Upper RAM selected |
| sel_sfr | output | 1 | SFR space selected |
| sel_xram | output | 1 | Expanded RAM selected |
| sel_ext | output | 1 | Off-chip port selected |
| ext_addr | output | 16 | Off-chip address (zero-extended for 8-bit moves) |
| ext_we | output | 1 | Off-chip write |
| ext_wdata | output | 8 | Off-chip write data |
| ext_rdata | input | 8 | Off-chip read data, valid while sel_ext |
| ale | output | 1 | Address latch enable |

## Verification
The bench writes the same address 90H directly and indirectly and reads both back. A router that decoded on address alone would return one value twice. It probes the expanded-RAM edge at 02FFH against 0300H, where an off-by-one would send the last byte off-chip or the first off-chip byte into on-chip storage. With bypass set, it writes an address that is also on-chip and then confirms the on-chip byte survived. It also drives an 8-bit move with junk in the high address byte, which a design without zero-extension would route off-chip. ALE is checked for exact 6-cycle spacing, then for silence while idle and during internal accesses once gating is on.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

  typedef enum logic [1:0] {
    AK_DIRECT   = 2'd0,
    AK_INDIRECT = 2'd1,
    AK_XMOVE16  = 2'd2,
    AK_XMOVE8   = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    TG_NONE    = 3'd0,
    TG_LORAM   = 3'd1,
    TG_HIRAM   = 3'd2,
    TG_SFR     = 3'd3,
    TG_XRAM    = 3'd4,
    TG_OFFCHIP = 3'd5
  } target_e;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned BANK_DEPTH = 128;
  localparam int unsigned NUM_BANKS = 3;

endpackage

// File: rtl/dmr_route.sv
module dmr_route
  import dmr_pkg::*;
#(
  parameter int unsigned XRAM_BYTES = 768
) (
  input  logic [1:0]        kind,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bypass,
  output target_e           target,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              xmove_act
);

  localparam logic [ADDR_W:0] XRAM_LIMIT = (ADDR_W+1)'(XRAM_BYTES);

  logic      active;
  acc_kind_e k;

  assign active = rd_en | wr_en;
  assign k      = acc_kind_e'(kind);

  always_comb begin
    target    = TG_NONE;
    eff_addr  = {8'h00, addr[7:0]};
    xmove_act = 1'b0;
    if (active) begin
      unique case (k)
        AK_DIRECT: begin
          target = addr[7] ? TG_SFR : TG_LORAM;
        end
        AK_INDIRECT: begin
          target = addr[7] ? TG_HIRAM : TG_LORAM;
        end
        AK_XMOVE16, AK_XMOVE8: begin
          xmove_act = 1'b1;
          if (k == AK_XMOVE16) begin
            eff_addr = addr;
          end
          if (!bypass && ({1'b0, eff_addr} < XRAM_LIMIT)) begin
            target = TG_XRAM;
          end else begin
            target = TG_OFFCHIP;
          end
        end
        default: target = TG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/dmr_ram.sv
module dmr_ram #(
  parameter  int unsigned DEPTH = 128,
  parameter  int unsigned DW    = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/dmr_ale.sv
module dmr_ale #(
  parameter  int unsigned PERIOD = 6,
  localparam int unsigned CW     = $clog2(PERIOD)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_off,
  input  logic xfer,
  output logic ale
);

  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          ale_q, ale_d;

  assign cnt_en = ~gate_off;

  always_comb begin
    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    ale_d = gate_off ? xfer : (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ale_q <= 1'b0;
    end else begin
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      ale_q <= ale_d;
    end
  end

  assign ale = ale_q;

endmodule

// File: rtl/dmem_router.sv
module dmem_router
  import dmr_pkg::*;
#(
  parameter  int unsigned XRAM_BYTES = 768,
  parameter  int unsigned ALE_PERIOD = 6,
  parameter  logic [7:0]  AUX_ADDR   = 8'h8E,
  localparam int unsigned XAW        = $clog2(XRAM_BYTES),
  localparam int unsigned BAW        = $clog2(BANK_DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  acc_kind,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic        code_rd,
  output logic [7:0]  rdata,
  output logic        rvalid,
  output logic        sel_lo,
  output logic        sel_hi,
  output logic        sel_sfr,
  output logic        sel_xram,
  output logic        sel_ext,
  output logic [15:0] ext_addr,
  output logic        ext_we,
  output logic [7:0]  ext_wdata,
  input  logic [7:0]  ext_rdata,
  output logic        ale
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_q1, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_q1     <= 1'b1;
      rst_sync_n <= rst_q1;
    end
  end

  // routing decision
  target_e           target;
  logic [ADDR_W-1:0] eff_addr;
  logic              xmove_act;
  logic [1:0]        aux_q, aux_d;
  logic              aux_en;

  dmr_route #(.XRAM_BYTES(XRAM_BYTES)) u_route (
    .kind      (acc_kind),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .bypass    (aux_q[1]),
    .target    (target),
    .eff_addr  (eff_addr),
    .xmove_act (xmove_act)
  );

  assign sel_lo   = (target == TG_LORAM);
  assign sel_hi   = (target == TG_HIRAM);
  assign sel_sfr  = (target == TG_SFR);
  assign sel_xram = (target == TG_XRAM);
  assign sel_ext  = (target == TG_OFFCHIP);

  // auxiliary control register
  logic aux_hit;

  assign aux_hit = sel_sfr & (addr[7:0] == AUX_ADDR);
  assign aux_en  = aux_hit & wr_en;
  assign aux_d   = wdata[1:0];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      aux_q <= 2'b00;
    end else if (aux_en) begin
      aux_q <= aux_d;
    end
  end

  // internal banks: 0 lower RAM, 1 upper RAM, 2 SFR stub
  logic [NUM_BANKS-1:0] bank_we;
  logic [DATA_W-1:0]    bank_rd [NUM_BANKS];

  assign bank_we[0] = wr_en & sel_lo;
  assign bank_we[1] = wr_en & sel_hi;
  assign bank_we[2] = wr_en & sel_sfr & ~aux_hit;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    dmr_ram #(.DEPTH(BANK_DEPTH), .DW(DATA_W)) u_bank (
      .clk   (clk),
      .we    (bank_we[g]),
      .addr  (addr[BAW-1:0]),
      .wdata (wdata),
      .rdata (bank_rd[g])
    );
  end

  // expanded RAM
  logic              xram_we;
  logic [DATA_W-1:0] xram_rd;

  assign xram_we = wr_en & sel_xram;

  dmr_ram #(.DEPTH(XRAM_BYTES), .DW(DATA_W)) u_xram (
    .clk   (clk),
    .we    (xram_we),
    .addr  (eff_addr[XAW-1:0]),
    .wdata (wdata),
    .rdata (xram_rd)
  );

  // off-chip port
  assign ext_addr  = eff_addr;
  assign ext_we    = sel_ext & wr_en;
  assign ext_wdata = wdata;

  // read return path
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              rdata_en;

  always_comb begin
    unique case (target)
      TG_LORAM:   rd_mux = bank_rd[0];
      TG_HIRAM:   rd_mux = bank_rd[1];
      TG_SFR:     rd_mux = aux_hit ? {6'b000000, aux_q} : bank_rd[2];
      TG_XRAM:    rd_mux = xram_rd;
      TG_OFFCHIP: rd_mux = ext_rdata;
      default:    rd_mux = '0;
    endcase
  end

  assign rdata_en = rd_en;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rdata_en) begin
        rdata_q <= rd_mux;
      end
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  // address latch enable
  logic ale_xfer;

  assign ale_xfer = xmove_act | code_rd;

  dmr_ale #(.PERIOD(ALE_PERIOD)) u_ale (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .gate_off (aux_q[0]),
    .xfer     (ale_xfer),
    .ale      (ale)
  );

endmodule

// File: rtl/dmr_checker.sv
module dmr_checker #(
  parameter int unsigned XRAM_BYTES = 768
) (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  acc_kind,
  input logic        rd_en,
  input logic        wr_en,
  input logic [15:0] addr,
  input logic        code_rd,
  input logic        sel_lo,
  input logic        sel_hi,
  input logic        sel_sfr,
  input logic        sel_xram,
  input logic        sel_ext,
  input logic        rvalid,
  input logic [7:0]  rdata,
  input logic        ale,
  input logic [1:0]  aux
);

  logic        active;
  logic        is_x;
  logic [16:0] eff;
  logic [4:0]  sels;
  logic        xfer_any;

  assign active   = rd_en | wr_en;
  assign is_x     = acc_kind[1];
  assign eff      = (acc_kind == 2'd3) ? {9'd0, addr[7:0]} : {1'b0, addr};
  assign sels     = {sel_lo, sel_hi, sel_sfr, sel_xram, sel_ext};
  assign xfer_any = (active && is_x) || code_rd;

  p_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
    active && !is_x && !addr[7] |-> sel_lo);
  p_sfr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active && acc_kind == 2'd0 && addr[7] |-> sel_sfr);
  p_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active && acc_kind == 2'd1 && addr[7] |-> sel_hi);
  p_aux_rsv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && $past(rd_en && acc_kind == 2'd0 && addr[7:0] == 8'h8E) |-> rdata[7:2] == 6'd0);
  p_xram_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active && is_x && !aux[1] && eff < 17'(XRAM_BYTES) |-> sel_xram);
  p_offchip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active && is_x && !aux[1] && eff >= 17'(XRAM_BYTES) |-> sel_ext);
  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active && is_x && aux[1] |-> sel_ext);
  p_zext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    active && acc_kind == 2'd3 && !aux[1] |-> !sel_ext);
  p_rvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  p_norvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> $countones(sels) == 1);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> sels == 5'd0);
  p_aleoff_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(aux[0]) && !$past(xfer_any) |-> !ale);

endmodule

bind dmem_router dmr_checker #(.XRAM_BYTES(XRAM_BYTES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .acc_kind (acc_kind),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .addr     (addr),
  .code_rd  (code_rd),
  .sel_lo   (sel_lo),
  .sel_hi   (sel_hi),
  .sel_sfr  (sel_sfr),
  .sel_xram (sel_xram),
  .sel_ext  (sel_ext),
  .rvalid   (rvalid),
  .rdata    (rdata),
  .ale      (ale),
  .aux      (aux_q)
);

// File: tb/dmem_router_tb.sv
`timescale 1ns/1ps
module dmem_router_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  acc_kind = 2'd0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] addr = 16'h0;
  logic [7:0]  wdata = 8'h0;
  logic        code_rd = 1'b0;
  logic [7:0]  rdata;
  logic        rvalid;
  logic        sel_lo, sel_hi, sel_sfr, sel_xram, sel_ext;
  logic [15:0] ext_addr;
  logic        ext_we;
  logic [7:0]  ext_wdata;
  logic [7:0]  ext_rdata;
  logic        ale;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [4:0] S_LO = 5'b10000, S_HI = 5'b01000, S_SFR = 5'b00100,
                         S_XR = 5'b00010, S_EX = 5'b00001;
  localparam logic [1:0] K_DIR = 2'd0, K_IND = 2'd1, K_X16 = 2'd2, K_X8 = 2'd3;

  always #5 clk = ~clk;

  function automatic logic [7:0] offv(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign ext_rdata = offv(ext_addr);

  dmem_router u_dut (
    .clk(clk), .rst_n(rst_n), .acc_kind(acc_kind), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .code_rd(code_rd), .rdata(rdata), .rvalid(rvalid),
    .sel_lo(sel_lo), .sel_hi(sel_hi), .sel_sfr(sel_sfr), .sel_xram(sel_xram),
    .sel_ext(sel_ext), .ext_addr(ext_addr), .ext_we(ext_we), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata), .ale(ale)
  );

  wire [4:0] sels = {sel_lo, sel_hi, sel_sfr, sel_xram, sel_ext};

  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: one access per cycle, expected read data queued for the monitor
  task automatic acc(input logic [1:0] k, input logic r, input logic w, input logic [15:0] a,
                     input logic [7:0] d, input logic [4:0] exp_sel, input logic [7:0] exp_rd,
                     input logic [15:0] exp_ea, input string tag);
    @(negedge clk);
    acc_kind = k; rd_en = r; wr_en = w; addr = a; wdata = d;
    #1;
    check(sels == exp_sel, {tag, " R9 select"}, 32'(sels), 32'(exp_sel));
    if (exp_sel == S_EX) begin
      check(ext_addr == exp_ea, {tag, " ext_addr"}, 32'(ext_addr), 32'(exp_ea));
      check(ext_we == w, {tag, " ext_we"}, 32'(ext_we), 32'(w));
      if (w) check(ext_wdata == d, {tag, " ext_wdata"}, 32'(ext_wdata), 32'(d));
    end
    if (r) begin
      exp_q.push_back(exp_rd);
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0; code_rd = 1'b0;
    end
  endtask

  // monitor: scoreboard pops on every valid read
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected rvalid", 32'(rdata), 32'h0);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rdata == e, {t, " R8 data"}, 32'(rdata), 32'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int last;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(rvalid == 1'b0, "R8 reset rvalid", 32'(rvalid), 32'd0);
    check(sels == 5'd0, "R9 idle select", 32'(sels), 32'd0);

    // R3 reset value
    acc(K_DIR, 1, 0, 16'h008E, 8'h00, S_SFR, 8'h00, 16'h0, "R3 aux reset");

    // R1 lower RAM, both modes share storage
    acc(K_DIR, 0, 1, 16'h0010, 8'hA5, S_LO, 8'h00, 16'h0, "R1 wr dir");
    acc(K_IND, 0, 1, 16'hFF20, 8'h3C, S_LO, 8'h00, 16'h0, "R1 wr ind");
    acc(K_IND, 1, 0, 16'h0010, 8'h00, S_LO, 8'hA5, 16'h0, "R1 rd ind");
    acc(K_DIR, 1, 0, 16'h0020, 8'h00, S_LO, 8'h3C, 16'h0, "R1 rd dir");

    // R2 same address, separate spaces
    acc(K_DIR, 0, 1, 16'h0090, 8'h11, S_SFR, 8'h00, 16'h0, "R2 wr sfr");
    acc(K_IND, 0, 1, 16'h0090, 8'h22, S_HI, 8'h00, 16'h0, "R2 wr hi");
    acc(K_DIR, 1, 0, 16'h0090, 8'h00, S_SFR, 8'h11, 16'h0, "R2 rd sfr");
    acc(K_IND, 1, 0, 16'h0090, 8'h00, S_HI, 8'h22, 16'h0, "R2 rd hi");
    acc(K_IND, 0, 1, 16'h008E, 8'h66, S_HI, 8'h00, 16'h0, "R2 wr hi 8E");
    acc(K_DIR, 1, 0, 16'h008E, 8'h00, S_SFR, 8'h00, 16'h0, "R2 aux untouched");
    acc(K_IND, 1, 0, 16'h008E, 8'h00, S_HI, 8'h66, 16'h0, "R2 rd hi 8E");

    // R3 reserved bits
    acc(K_DIR, 0, 1, 16'h008E, 8'hFC, S_SFR, 8'h00, 16'h0, "R3 wr FC");
    acc(K_DIR, 1, 0, 16'h008E, 8'h00, S_SFR, 8'h00, 16'h0, "R3 rd FC");
    acc(K_DIR, 0, 1, 16'h008E, 8'hFF, S_SFR, 8'h00, 16'h0, "R3 wr FF");
    acc(K_DIR, 1, 0, 16'h008E, 8'h00, S_SFR, 8'h03, 16'h0, "R3 rd FF");
    acc(K_DIR, 0, 1, 16'h008E, 8'h00, S_SFR, 8'h00, 16'h0, "R3 clr");

    // R4 expanded RAM window
    acc(K_X16, 0, 1, 16'h0000, 8'h01, S_XR, 8'h00, 16'h0, "R4 wr 000");
    acc(K_X16, 0, 1, 16'h02FF, 8'hFE, S_XR, 8'h00, 16'h0, "R4 wr 2FF");
    acc(K_X16, 0, 1, 16'h0150, 8'h77, S_XR, 8'h00, 16'h0, "R4 wr 150");
    acc(K_X16, 1, 0, 16'h0000, 8'h00, S_XR, 8'h01, 16'h0, "R4 rd 000");
    acc(K_X16, 1, 0, 16'h02FF, 8'h00, S_XR, 8'hFE, 16'h0, "R4 rd 2FF");
    acc(K_X16, 1, 0, 16'h0150, 8'h00, S_XR, 8'h77, 16'h0, "R4 rd 150");

    // R5 above the window
    acc(K_X16, 1, 0, 16'h0300, 8'h00, S_EX, offv(16'h0300), 16'h0300, "R5 rd 300");
    acc(K_X16, 0, 1, 16'h1234, 8'h9D, S_EX, 8'h00, 16'h1234, "R5 wr 1234");
    acc(K_X16, 1, 0, 16'hFFFF, 8'h00, S_EX, offv(16'hFFFF), 16'hFFFF, "R5 rd FFFF");

    // R7 8-bit move zero-extends
    acc(K_X8, 0, 1, 16'hAB55, 8'hC3, S_XR, 8'h00, 16'h0, "R7 wr 8bit");
    acc(K_X16, 1, 0, 16'h0055, 8'h00, S_XR, 8'hC3, 16'h0, "R7 rd 0055");

    // R6 bypass sends everything off-chip
    acc(K_DIR, 0, 1, 16'h008E, 8'h02, S_SFR, 8'h00, 16'h0, "R6 set bypass");
    acc(K_X16, 1, 0, 16'h0000, 8'h00, S_EX, offv(16'h0000), 16'h0000, "R6 rd 000");
    acc(K_X16, 0, 1, 16'h0150, 8'hEE, S_EX, 8'h00, 16'h0150, "R6 wr 150");
    acc(K_X8, 1, 0, 16'h9977, 8'h00, S_EX, offv(16'h0077), 16'h0077, "R7 R6 8bit off");
    acc(K_DIR, 0, 1, 16'h008E, 8'h00, S_SFR, 8'h00, 16'h0, "R6 clr bypass");
    acc(K_X16, 1, 0, 16'h0150, 8'h00, S_XR, 8'h77, 16'h0, "R6 xram kept");
    idle(3);

    // R10 constant-rate ALE
    last = -1; cnt = 0;
    for (int i = 0; i < 36; i++) begin
      @(negedge clk);
      if (ale) begin
        if (last >= 0) check((i - last) == 6, "R10 ale spacing", 32'(i - last), 32'd6);
        cnt++;
        last = i;
      end
    end
    check(cnt == 6, "R10 ale count", 32'(cnt), 32'd6);

    // R11 gated ALE
    acc(K_DIR, 0, 1, 16'h008E, 8'h01, S_SFR, 8'h00, 16'h0, "R11 gate on");
    idle(2);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ale) cnt++;
    end
    check(cnt == 0, "R11 idle quiet", 32'(cnt), 32'd0);
    acc(K_DIR, 1, 0, 16'h0010, 8'h00, S_LO, 8'hA5, 16'h0, "R11 internal rd");
    idle(1);
    #1 check(ale == 1'b0, "R11 internal no ale", 32'(ale), 32'd0);
    acc(K_X16, 1, 0, 16'h0150, 8'h00, S_XR, 8'h77, 16'h0, "R11 xmove");
    idle(1);
    #1 check(ale == 1'b1, "R11 ale after xmove", 32'(ale), 32'd1);
    idle(1);
    #1 check(ale == 1'b0, "R11 ale one cycle", 32'(ale), 32'd0);
    @(negedge clk); code_rd = 1'b1;
    idle(1);
    #1 check(ale == 1'b1, "R11 ale after code read", 32'(ale), 32'd1);
    idle(1);
    #1 check(ale == 1'b0, "R11 ale drops", 32'(ale), 32'd0);

    idle(4);
    check(exp_q.size() == 0, "R8 reads outstanding", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule